// File: doc/BRIEF.md
# Load/Store Address Generation and Byte-Lane Steering Unit

This unit sits between the register read stage and a byte-addressed 32-bit data memory port. For every load or store request it forms the effective byte address from a base value and an offset, decides whether the base register is updated afterwards, and moves the access data onto the lanes of the memory word that the access touches. The offset is either a 12-bit unsigned constant or a second register value shifted left by a programmable amount. The offset can be added to the base or subtracted from it.

Three indexing styles are offered. Plain offset addressing accesses base±offset and leaves the base alone. Pre-indexing accesses base±offset and also returns that sum as the new base. Post-indexing accesses the unmodified base and returns base±offset as the new base. Accesses may be bytes, halfwords or words. Byte ordering inside a word is a configuration pin that is captured only while reset is held. Loads are zero-extended. Misaligned halfword or word accesses are refused and flagged.

All request results appear on registered outputs one clock after the request. The load result is produced combinationally from the memory read word during that same output cycle.

Top module: `mem_access_steer`

## Requirements
- R1: The byte order is taken from `cfg_big_end` while `rst_n` is low (0 = little, 1 = big). Changing `cfg_big_end` after reset release has no effect on lane placement.
- R2: The offset is `req_imm` zero-extended when `req_use_reg`=0, and `req_roff` shifted left by `req_shamt` when `req_use_reg`=1. It is subtracted from `req_base` when `req_sub`=1 and added otherwise, modulo 2^32.
- R3: Mode code 0 or 3 (plain offset) accesses base±offset and keeps `wb_en` low.
- R4: Mode code 1 (pre-index) accesses base±offset and raises `wb_en` with `wb_value` equal to that same sum.
- R5: Mode code 2 (post-index) accesses `req_base` unchanged and raises `wb_en` with `wb_value` = base±offset.
- R6: Size code 0 is a byte, 1 a halfword, and 2 or 3 a word. The access covers consecutive byte addresses starting at `mem_addr`. A byte at address offset k within the word sits in lane k (bits 8k+7:8k) in little mode and in lane 3−k in big mode. `mem_be` bit L is set exactly for the lanes the access covers.
- R7: For a store, `mem_wdata` carries the low 8×n bits of `req_wdata` on the enabled lanes, in the request's byte order, with all other lanes zero. In little mode the first byte address holds the least significant byte. In big mode it holds the most significant byte.
- R8: For a load, `ld_data` holds the accessed bytes of `mem_rdata` assembled in the same byte order, zero-extended to 32 bits.
- R9: A halfword at an odd address, or a word whose address has nonzero bits 1:0, raises `align_err` and keeps `mem_valid` and `wb_en` low.
- R10: Results appear on the outputs exactly one clock after `req_valid`. With no request, and in reset, `mem_valid`, `mem_write`, `mem_be`, `wb_en` and `align_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_big_end | input | 1 | Byte-order select, captured during reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_mode | input | 2 | Indexing mode code |
| req_base | input | 32 | Base register value |
| req_use_reg | input | 1 | Offset source: 1 = register, 0 = constant |
| req_imm | input | 12 | Unsigned constant offset |
| req_roff | input | 32 | Register offset value |
| req_shamt | input | 5 | Left shift applied to register offset |
| req_sub | input | 1 | Subtract offset instead of adding |
| req_wdata | input | 32 | Store value, right-justified |
| mem_rdata | input | 32 | Memory read word for the current output cycle |
| mem_valid | output | 1 | Memory access issued |
| mem_write | output | 1 | Access is a store |
| mem_addr | output | 32 | Byte address of the access |
| mem_be | output | 4 | Lane enables |
| mem_wdata | output | 32 | Store data placed on lanes |
| ld_data | output | 32 | Zero-extended load result |
| wb_en | output | 1 | Base register update valid |
| wb_value | output | 32 | New base register value |
| align_err | output | 1 | Misaligned access refused |

## Verification
A wrong captured byte order shows up on the very next access of any size below a word. The enabled lane mirrors within the word and the store lanes and load result swap, so a single byte store at a known address exposes it. An adder or mode-select fault shows in the same output cycle as a wrong `mem_addr` or `wb_value`. A lane-base error misplaces `mem_be` and scrambles bytes. A following load from the bench's byte-array memory also reveals it, because that load reads the wrong bytes back. A stuck output register shows as results one cycle early or late, or as enables that linger on idle cycles.

// File: rtl/msteer_pkg.sv
package msteer_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WORD_ALT = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      IX_OFFSET = 2'd0,
      IX_PRE = 2'd1,
      IX_POST = 2'd2,
      IX_OFFSET_ALT = 2'd3
   } index_mode_e;
endpackage

// File: rtl/msteer_offset_gen.sv
module msteer_offset_gen
   import msteer_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IMM_W = 12,
   parameter int SHAMT_W = 5
) (
   input logic [ADDR_W-1:0] base,
   input logic use_reg,
   input logic [IMM_W-1:0] imm,
   input logic [ADDR_W-1:0] roff,
   input logic [SHAMT_W-1:0] shamt,
   input logic sub,
   input index_mode_e mode,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [ADDR_W-1:0] new_base,
   output logic wb_req
);
   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] sum;

   always_comb begin
      offset = use_reg ? (roff << shamt) : {{(ADDR_W-IMM_W){1'b0}}, imm};
      sum = sub ? (base - offset) : (base + offset);
      new_base = sum;
      unique case (mode)
         IX_POST: begin acc_addr = base; wb_req = 1'b1; end
         IX_PRE: begin acc_addr = sum; wb_req = 1'b1; end
         default: begin acc_addr = sum; wb_req = 1'b0; end
      endcase
   end
endmodule

// File: rtl/msteer_lane_place.sv
module msteer_lane_place
   import msteer_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int LB_W = $clog2(LANES)
) (
   input logic big,
   input acc_size_e size,
   input logic [LB_W-1:0] addr_lo,
   input logic [DATA_W-1:0] wdata,
   output logic [LANES-1:0] be,
   output logic [DATA_W-1:0] wlanes,
   output logic [LB_W-1:0] lane_base
);
   logic [LB_W:0] nbytes;
   logic [LB_W:0] lo_ext;
   logic [LB_W:0] hi_ext;
   logic [DATA_W-1:0] wmask;

   always_comb begin
      unique case (size)
         SZ_BYTE: nbytes = (LB_W+1)'(1);
         SZ_HALF: nbytes = (LB_W+1)'(2);
         default: nbytes = (LB_W+1)'(LANES);
      endcase
      lo_ext = big ? ((LB_W+1)'(LANES) - nbytes - {1'b0, addr_lo}) : {1'b0, addr_lo};
      lane_base = lo_ext[LB_W-1:0];
      hi_ext = {1'b0, lane_base} + nbytes;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam logic [LB_W:0] LIDX = (LB_W+1)'(l);
      assign be[l] = (LIDX >= {1'b0, lane_base}) && (LIDX < hi_ext);
      assign wmask[8*l +: 8] = {8{LIDX < nbytes}};
   end

   assign wlanes = (wdata & wmask) << {lane_base, 3'b000};
endmodule

// File: rtl/msteer_load_extract.sv
module msteer_load_extract
   import msteer_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int LB_W = $clog2(LANES)
) (
   input logic [DATA_W-1:0] rdata,
   input logic [LB_W-1:0] lane_base,
   input acc_size_e size,
   output logic [DATA_W-1:0] ld_data
);
   logic [LB_W:0] nbytes;
   logic [DATA_W-1:0] keep;
   logic [DATA_W-1:0] shifted;

   always_comb begin
      unique case (size)
         SZ_BYTE: nbytes = (LB_W+1)'(1);
         SZ_HALF: nbytes = (LB_W+1)'(2);
         default: nbytes = (LB_W+1)'(LANES);
      endcase
   end

   for (genvar j = 0; j < LANES; j++) begin : g_keep
      localparam logic [LB_W:0] JIDX = (LB_W+1)'(j);
      assign keep[8*j +: 8] = {8{JIDX < nbytes}};
   end

   assign shifted = rdata >> {lane_base, 3'b000};
   assign ld_data = shifted & keep;
endmodule

// File: rtl/mem_access_steer.sv
module mem_access_steer
   import msteer_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int IMM_W = 12,
   parameter int SHAMT_W = 5,
   localparam int LANES = DATA_W / 8,
   localparam int LB_W = $clog2(LANES)
) (
   input logic clk,
   input logic rst_n,
   input logic cfg_big_end,
   input logic req_valid,
   input logic req_store,
   input logic [1:0] req_size,
   input logic [1:0] req_mode,
   input logic [ADDR_W-1:0] req_base,
   input logic req_use_reg,
   input logic [IMM_W-1:0] req_imm,
   input logic [ADDR_W-1:0] req_roff,
   input logic [SHAMT_W-1:0] req_shamt,
   input logic req_sub,
   input logic [DATA_W-1:0] req_wdata,
   input logic [DATA_W-1:0] mem_rdata,
   output logic mem_valid,
   output logic mem_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LANES-1:0] mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] ld_data,
   output logic wb_en,
   output logic [ADDR_W-1:0] wb_value,
   output logic align_err
);
   if (DATA_W != 32) begin : g_bad_data_w
      $error("mem_access_steer: DATA_W must be 32");
   end
   if (IMM_W >= ADDR_W || IMM_W < 1) begin : g_bad_imm_w
      $error("mem_access_steer: IMM_W must be between 1 and ADDR_W-1");
   end
   if ((1 << SHAMT_W) > ADDR_W) begin : g_bad_shamt_w
      $error("mem_access_steer: SHAMT_W too wide for ADDR_W");
   end

   acc_size_e size_in;
   index_mode_e mode_in;
   assign size_in = acc_size_e'(req_size);
   assign mode_in = index_mode_e'(req_mode);

   logic big_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) big_q <= cfg_big_end;
   end

   logic [ADDR_W-1:0] acc_addr;
   logic [ADDR_W-1:0] new_base;
   logic wb_req;

   msteer_offset_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)) u_ofs (
      .base(req_base), .use_reg(req_use_reg), .imm(req_imm), .roff(req_roff),
      .shamt(req_shamt), .sub(req_sub), .mode(mode_in),
      .acc_addr(acc_addr), .new_base(new_base), .wb_req(wb_req)
   );

   logic [LANES-1:0] be_c;
   logic [DATA_W-1:0] wlanes_c;
   logic [LB_W-1:0] lane_base_c;

   msteer_lane_place #(.DATA_W(DATA_W)) u_place (
      .big(big_q), .size(size_in), .addr_lo(acc_addr[LB_W-1:0]), .wdata(req_wdata),
      .be(be_c), .wlanes(wlanes_c), .lane_base(lane_base_c)
   );

   logic misaligned;
   always_comb begin
      unique case (size_in)
         SZ_BYTE: misaligned = 1'b0;
         SZ_HALF: misaligned = acc_addr[0];
         default: misaligned = |acc_addr[LB_W-1:0];
      endcase
   end

   logic go;
   assign go = req_valid && !misaligned;

   logic [LB_W-1:0] lane_base_q;
   acc_size_e size_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_valid <= 1'b0;
         mem_write <= 1'b0;
         mem_addr <= '0;
         mem_be <= '0;
         mem_wdata <= '0;
         wb_en <= 1'b0;
         wb_value <= '0;
         align_err <= 1'b0;
         lane_base_q <= '0;
         size_q <= SZ_BYTE;
      end else begin
         mem_valid <= go;
         mem_write <= go && req_store;
         mem_addr <= acc_addr;
         mem_be <= go ? be_c : '0;
         mem_wdata <= (go && req_store) ? wlanes_c : '0;
         wb_en <= go && wb_req;
         wb_value <= new_base;
         align_err <= req_valid && misaligned;
         lane_base_q <= lane_base_c;
         size_q <= size_in;
      end
   end

   msteer_load_extract #(.DATA_W(DATA_W)) u_extract (
      .rdata(mem_rdata), .lane_base(lane_base_q), .size(size_q), .ld_data(ld_data)
   );
endmodule

// File: rtl/msteer_chk.sv
module msteer_chk #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic big_q,
   input logic mem_valid,
   input logic mem_write,
   input logic [LANES-1:0] mem_be,
   input logic [DATA_W-1:0] ld_data,
   input logic wb_en,
   input logic align_err
);
   p_order_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(big_q));

   p_lane_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

   p_store_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_write) |-> (mem_be != '0));

   p_zero_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_write && $countones(mem_be) == 1) |-> ((ld_data >> 8) == '0));

   p_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
      align_err |-> (!mem_valid && !wb_en));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_valid) |-> (!mem_valid && !wb_en && !align_err && !mem_write));

   p_wb_needs_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> mem_valid);
endmodule

bind mem_access_steer msteer_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .big_q(big_q),
   .mem_valid(mem_valid), .mem_write(mem_write), .mem_be(mem_be),
   .ld_data(ld_data), .wb_en(wb_en), .align_err(align_err)
);

// File: tb/sim_mem_access_steer.sv
`timescale 1ns/1ps
module sim_mem_access_steer;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_big_end = 1'b0;
   logic req_valid = 1'b0;
   logic req_store = 1'b0;
   logic [1:0] req_size = '0;
   logic [1:0] req_mode = '0;
   logic [31:0] req_base = '0;
   logic req_use_reg = 1'b0;
   logic [11:0] req_imm = '0;
   logic [31:0] req_roff = '0;
   logic [4:0] req_shamt = '0;
   logic req_sub = 1'b0;
   logic [31:0] req_wdata = '0;
   logic [31:0] mem_rdata;
   logic mem_valid, mem_write, wb_en, align_err;
   logic [31:0] mem_addr, mem_wdata, ld_data, wb_value;
   logic [3:0] mem_be;

   always #2.5 clk = ~clk;

   mem_access_steer u0 (
      .clk(clk), .rst_n(rst_n), .cfg_big_end(cfg_big_end), .req_valid(req_valid),
      .req_store(req_store), .req_size(req_size), .req_mode(req_mode), .req_base(req_base),
      .req_use_reg(req_use_reg), .req_imm(req_imm), .req_roff(req_roff),
      .req_shamt(req_shamt), .req_sub(req_sub), .req_wdata(req_wdata),
      .mem_rdata(mem_rdata), .mem_valid(mem_valid), .mem_write(mem_write),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .ld_data(ld_data),
      .wb_en(wb_en), .wb_value(wb_value), .align_err(align_err)
   );

   logic [7:0] mem [64];
   logic tb_big = 1'b0;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // Byte-array memory: lane placement from the requirement text (R6)
   always_comb begin
      for (int l = 0; l < 4; l++) begin
         int k;
         k = tb_big ? 3 - l : l;
         mem_rdata[8*l +: 8] = mem[{mem_addr[5:2], 2'(k)}];
      end
   end

   typedef struct {
      string tag;
      bit valid;
      bit err;
      bit store;
      logic [31:0] addr;
      logic [3:0] be;
      logic [31:0] wd;
      logic [31:0] ld;
      bit wb;
      logic [31:0] wbv;
      int nb;
      logic [31:0] data;
   } exp_t;

   exp_t q[$];

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic req(bit st, int sz, int md, logic [31:0] base, bit ur,
                      logic [11:0] imm, logic [31:0] roff, int sh, bit sb,
                      logic [31:0] data, string tag);
      exp_t e;
      logic [31:0] off, sum, acc;
      int n;
      @(negedge clk);
      req_valid = 1'b1; req_store = st; req_size = 2'(sz); req_mode = 2'(md);
      req_base = base; req_use_reg = ur; req_imm = imm; req_roff = roff;
      req_shamt = 5'(sh); req_sub = sb; req_wdata = data;
      off = ur ? (roff << sh) : {20'd0, imm};
      sum = sb ? base - off : base + off;
      acc = (md == 2) ? base : sum;
      n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      e.tag = tag; e.store = st; e.addr = acc; e.nb = n; e.data = data;
      e.err = (n == 2 && acc[0]) || (n == 4 && acc[1:0] != 2'b00);
      e.valid = !e.err;
      e.be = '0; e.wd = '0; e.ld = '0;
      for (int i = 0; i < n; i++) begin
         int a, lane;
         logic [7:0] b;
         a = int'(acc[1:0]) + i;
         lane = tb_big ? 3 - a : a;
         b = tb_big ? data[8*(n-1-i) +: 8] : data[8*i +: 8];
         if (lane >= 0 && lane < 4) begin
            e.be[lane] = 1'b1;
            if (st) e.wd[8*lane +: 8] = b;
         end
         if (tb_big) e.ld[8*(n-1-i) +: 8] = mem[6'(acc + 32'(i))];
         else e.ld[8*i +: 8] = mem[6'(acc + 32'(i))];
      end
      if (e.err) begin e.be = '0; e.wd = '0; end
      e.wb = !e.err && (md == 1 || md == 2);
      e.wbv = sum;
      q.push_back(e);
   endtask

   task automatic idle(int cycles);
      for (int c = 0; c < cycles; c++) begin
         exp_t e;
         @(negedge clk);
         req_valid = 1'b0;
         e.tag = "R10 idle"; e.valid = 0; e.err = 0; e.store = 0; e.wb = 0;
         e.be = '0; e.addr = '0; e.wd = '0; e.ld = '0; e.wbv = '0; e.nb = 0; e.data = '0;
         q.push_back(e);
      end
   endtask

   // Monitor: compare one expected item per cycle after the capturing edge
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk({e.tag, " mem_valid"}, 32'(mem_valid), 32'(e.valid));
         chk({e.tag, " R9 align_err"}, 32'(align_err), 32'(e.err));
         chk({e.tag, " wb_en"}, 32'(wb_en), 32'(e.wb));
         chk({e.tag, " R6 mem_be"}, 32'(mem_be), 32'(e.be));
         chk({e.tag, " mem_write"}, 32'(mem_write), 32'(e.valid && e.store));
         if (e.valid) chk({e.tag, " mem_addr"}, mem_addr, e.addr);
         if (e.wb) chk({e.tag, " wb_value"}, wb_value, e.wbv);
         if (e.valid && e.store) begin
            chk({e.tag, " R7 mem_wdata"}, mem_wdata, e.wd);
            for (int i = 0; i < e.nb; i++)
               mem[6'(e.addr + 32'(i))] = tb_big ? e.data[8*(e.nb-1-i) +: 8] : e.data[8*i +: 8];
         end
         if (e.valid && !e.store) chk({e.tag, " R8 ld_data"}, ld_data, e.ld);
      end
   end

   task automatic do_reset(bit big);
      @(negedge clk);
      rst_n = 1'b0; req_valid = 1'b0; cfg_big_end = big; tb_big = big;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R10 reset mem_valid", 32'(mem_valid), 0);
      chk("R10 reset mem_be", 32'(mem_be), 0);
      chk("R10 reset wb_en", 32'(wb_en), 0);
      chk("R10 reset align_err", 32'(align_err), 0);
   endtask

   task automatic suite();
      req(1, 2, 0, 32'h100, 0, 12'd8, 0, 0, 0, 32'h11223344, "R3 word store plain");
      req(0, 2, 0, 32'h100, 0, 12'd8, 0, 0, 0, 0, "R8 word load back");
      req(1, 0, 1, 32'h20, 0, 12'd3, 0, 0, 0, 32'hFFFF_FFA5, "R4 byte store pre");
      req(0, 0, 2, 32'h23, 1, 12'd0, 32'd4, 0, 1, 0, "R5 byte load post sub");
      req(1, 1, 1, 32'h10, 1, 12'd0, 32'd1, 2, 0, 32'hDEAD_BEEF, "R2 half store shifted");
      req(0, 1, 0, 32'h10, 1, 12'd0, 32'd1, 2, 0, 0, "R8 half load back");
      req(0, 0, 0, 32'h14, 0, 12'd1, 0, 0, 0, 0, "R6 byte order probe");
      req(0, 2, 1, 32'h11, 0, 12'd0, 0, 0, 0, 0, "R9 word misaligned pre");
      req(1, 1, 2, 32'h13, 0, 12'd4, 0, 0, 0, 32'h1234, "R9 half misaligned post");
      req(0, 3, 3, 32'h40, 0, 12'd16, 0, 0, 1, 0, "R3 word alt size sub");
      req(0, 0, 1, 32'h5, 1, 12'd0, 32'd1, 31, 0, 0, "R2 shift 31");
      idle(2);
      for (int m = 0; m < 4; m++)
         for (int s = 0; s < 4; s++)
            for (int lo = 0; lo < 4; lo++)
               for (int st = 0; st < 2; st++)
                  req(st[0], s, m, 32'h200 + 32'(lo), 0, 12'd8, 0, 0, 0,
                      32'hA1B2C3D4 ^ 32'(m*37 + s*11 + lo*3 + st), "R6 sweep");
      idle(3);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
      do_reset(1'b0);
      idle(1);
      suite();
      // R1: after release, the pin no longer steers lanes
      cfg_big_end = 1'b1;
      req(1, 0, 0, 32'h30, 0, 12'd0, 0, 0, 0, 32'h77, "R1 pin change ignored little");
      idle(2);
      do_reset(1'b1);
      idle(1);
      suite();
      cfg_big_end = 1'b0;
      req(1, 0, 0, 32'h30, 0, 12'd0, 0, 0, 0, 32'h66, "R1 pin change ignored big");
      idle(3);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R10 watchdog expired actual=hung expected=complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule